// File: doc/BRIEF.md
# Host Transaction Retry and Error Handler

This block decides what a host controller does after each token it sends to one endpoint. A transaction is armed with a one-cycle pulse. For every handshake outcome reported afterwards, the block does one of three things: it asks for the token to be sent again, it ends the transaction quietly on success, or it ends it with a status flag and an interrupt.

NAK replies and bus errors are counted separately. A bus error is a missing reply, a CRC error or a bit-stuff error. NAKs are retried until a programmable limit is reached, and a limit of zero means NAKs are retried without limit. Errors are retried until three attempts in a row have failed. A STALL is never retried.

When the error limit is reached, the action depends on direction. A receiving (IN) endpoint gets a pulse that clears its request-packet flag. A transmitting (OUT) endpoint gets a pulse that flushes its FIFO.

Top module: `txn_retry_ctl`

## Requirements
- R1: After reset, `active`, `stalled`, `err_flag`, `nak_tmo`, `retry`, `irq`, `req_clr` and `fifo_flush` are all 0.
- R2: An `arm` pulse sets `active` to 1, clears `stalled`, `err_flag` and `nak_tmo`, and zeroes both retry counters. This is visible on the cycle after the pulse.
- R3: The response code on `resp_code` uses this encoding: 0 ACK, 1 NAK, 2 STALL, 3 no reply, 4 CRC error, 5 bit-stuff error. A response is taken only when `resp_valid` is 1, `active` is 1 and `arm` is 0. All outputs are registered and change on the cycle after the response.
- R4: While the NAK count stays below a nonzero `nak_limit`, a NAK gives a one-cycle `retry` pulse and no `irq`.
- R5: The NAK that brings the count to a nonzero `nak_limit` sets `nak_tmo`, pulses `irq`, clears `active` and gives no `retry`.
- R6: With `nak_limit` equal to 0, any number of NAKs produces `retry` each time and never ends the transaction.
- R7: A STALL sets `stalled`, pulses `irq`, clears `active`, and gives no `retry`, `req_clr` or `fifo_flush`.
- R8: Codes 3, 4 and 5 count as errors. The first and second consecutive errors each give a `retry` pulse.
- R9: The third consecutive error sets `err_flag`, pulses `irq` and clears `active`. With `dir_out` equal to 0 (IN) it also pulses `req_clr`. With `dir_out` equal to 1 (OUT) it pulses `fifo_flush` instead.
- R10: A NAK resets the error count. An ACK resets both counts, clears `active`, and raises no `irq` and no flag.
- R11: Codes 6 and 7, and any response while `active` is 0, have no effect: no pulse, no flag change, and no change to either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new transaction |
| dir_out | input | 1 | 1 = OUT endpoint, 0 = IN endpoint |
| nak_limit | input | NAK_W | NAK retry limit, 0 = unlimited |
| resp_valid | input | 1 | Handshake outcome present |
| resp_code | input | 3 | Outcome code (see R3) |
| active | output | 1 | Transaction in progress |
| retry | output | 1 | Pulse: resend the token |
| irq | output | 1 | Pulse: interrupt |
| stalled | output | 1 | STALL received |
| err_flag | output | 1 | Error limit reached |
| nak_tmo | output | 1 | NAK limit reached |
| req_clr | output | 1 | Pulse: clear IN request flag |
| fifo_flush | output | 1 | Pulse: flush OUT FIFO |

## Verification
The bench sweeps NAK limits from 0 to 4 in both directions. A design with an off-by-one in the limit compare would end one NAK early or late. A design that treats zero as a real limit would stop an unlimited transaction.

Error runs of one to four are tried with a mix of error codes. This catches a design that ends after two or four errors, swaps the IN and OUT terminal pulses, or keeps reacting after it has ended.

Other sequences interleave NAK, ACK and ignored codes between errors. A design whose error count survives a NAK, or is changed by a reserved code or a late response, would end the transaction at the wrong attempt.

// File: rtl/txn_retry_ctl.sv
module txn_retry_ctl #(
  parameter int NAK_W     = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             dir_out,
  input  logic [NAK_W-1:0] nak_limit,
  input  logic             resp_valid,
  input  logic [2:0]       resp_code,
  output logic             active,
  output logic             retry,
  output logic             irq,
  output logic             stalled,
  output logic             err_flag,
  output logic             nak_tmo,
  output logic             req_clr,
  output logic             fifo_flush
);
  localparam int ERR_W = $clog2(ERR_TRIES + 1);
  localparam logic [2:0] C_ACK = 3'd0, C_NAK = 3'd1, C_STALL = 3'd2;

  logic [NAK_W-1:0] nak_cnt;
  logic [ERR_W-1:0] err_cnt;

  wire take     = active && resp_valid && !arm;
  wire is_ack   = take && resp_code == C_ACK;
  wire is_nak   = take && resp_code == C_NAK;
  wire is_stall = take && resp_code == C_STALL;
  wire is_err   = take && (resp_code >= 3'd3) && (resp_code <= 3'd5);

  wire [NAK_W:0] nak_next = {1'b0, nak_cnt} + 1'b1;
  wire [ERR_W:0] err_next = {1'b0, err_cnt} + 1'b1;
  wire nak_hit = is_nak && (nak_limit != '0) && (nak_next >= {1'b0, nak_limit});
  wire err_hit = is_err && (err_next >= (ERR_W+1)'(ERR_TRIES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; retry <= 1'b0; irq <= 1'b0;
      stalled <= 1'b0; err_flag <= 1'b0; nak_tmo <= 1'b0;
      req_clr <= 1'b0; fifo_flush <= 1'b0;
      nak_cnt <= '0; err_cnt <= '0;
    end else begin
      retry <= 1'b0; irq <= 1'b0; req_clr <= 1'b0; fifo_flush <= 1'b0;
      if (arm) begin
        active <= 1'b1;
        stalled <= 1'b0; err_flag <= 1'b0; nak_tmo <= 1'b0;
        nak_cnt <= '0; err_cnt <= '0;
      end else if (is_ack) begin
        active <= 1'b0;
        nak_cnt <= '0; err_cnt <= '0;
      end else if (is_nak) begin
        err_cnt <= '0;
        if (nak_cnt != '1) nak_cnt <= nak_next[NAK_W-1:0];
        if (nak_hit) begin
          active <= 1'b0; nak_tmo <= 1'b1; irq <= 1'b1;
        end else begin
          retry <= 1'b1;
        end
      end else if (is_stall) begin
        active <= 1'b0; stalled <= 1'b1; irq <= 1'b1;
      end else if (is_err) begin
        err_cnt <= err_next[ERR_W-1:0];
        if (err_hit) begin
          active <= 1'b0; err_flag <= 1'b1; irq <= 1'b1;
          req_clr <= !dir_out; fifo_flush <= dir_out;
        end else begin
          retry <= 1'b1;
        end
      end
    end
  end

  a_r7_stall_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (active && resp_valid && !arm && resp_code == C_STALL) |=> (!retry && irq && stalled && !active));

  a_r9_one_terminal_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_clr && fifo_flush));

  a_r3_retry_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry && irq));

  a_r5_irq_ends_txn: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !active);

  a_r11_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !arm) |=> (!retry && !irq && !active));

  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (active && !stalled && !err_flag && !nak_tmo));
endmodule

// File: tb/txn_retry_ctl_tb.sv
module txn_retry_ctl_tb;
  logic clk = 0, rst_n = 0, arm = 0, dir_out = 0, resp_valid = 0;
  logic [7:0] nak_limit = 0;
  logic [2:0] resp_code = 0;
  logic active, retry, irq, stalled, err_flag, nak_tmo, req_clr, fifo_flush;
  int vecs = 0, bad = 0;

  always #5 clk = ~clk;

  txn_retry_ctl u_dut (.clk, .rst_n, .arm, .dir_out, .nak_limit, .resp_valid, .resp_code,
    .active, .retry, .irq, .stalled, .err_flag, .nak_tmo, .req_clr, .fifo_flush);

  task automatic chk(string req, string what, logic got, logic exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic resp(logic [2:0] c);
    @(negedge clk); resp_valid = 1; resp_code = c;
    @(negedge clk); resp_valid = 0;
  endtask

  task automatic expect_out(string req, logic a, logic r, logic i, logic rc, logic ff);
    chk(req, "active", active, a);
    chk(req, "retry", retry, r);
    chk(req, "irq", irq, i);
    chk(req, "req_clr", req_clr, rc);
    chk(req, "fifo_flush", fifo_flush, ff);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1", 0, 0, 0, 0, 0);
    chk("R1", "flags", stalled | err_flag | nak_tmo, 0);
    @(negedge clk); rst_n = 1;

    // R4 R5 R6: NAK limit sweep
    for (int d = 0; d < 2; d++) begin
      for (int lim = 0; lim < 5; lim++) begin
        dir_out = d[0]; nak_limit = 8'(lim);
        do_arm();
        chk("R2", "active after arm", active, 1);
        for (int i = 1; i <= 6; i++) begin
          logic live, term;
          live = (lim == 0) || (i <= lim);
          term = (lim != 0) && (i == lim);
          resp(3'd1);
          expect_out(lim == 0 ? "R6" : (term ? "R5" : "R4"), live && !term, live && !term, term, 0, 0);
          chk("R5", "nak_tmo", nak_tmo, (lim != 0) && (i >= lim));
        end
      end
    end

    // R8 R9: error run sweep
    nak_limit = 0;
    for (int d = 0; d < 2; d++) begin
      dir_out = d[0];
      do_arm();
      chk("R2", "nak_tmo cleared", nak_tmo, 0);
      for (int i = 1; i <= 4; i++) begin
        logic term, live;
        term = (i == 3); live = (i <= 3);
        resp(3'(3 + (i % 3)));
        expect_out(term ? "R9" : "R8", live && !term, live && !term, term, term && d == 0, term && d == 1);
        chk("R9", "err_flag", err_flag, i >= 3);
      end
    end

    // R10: NAK resets error count
    dir_out = 0; do_arm();
    resp(3'd3); resp(3'd4);
    resp(3'd1); expect_out("R10", 1, 1, 0, 0, 0);
    resp(3'd5); expect_out("R10", 1, 1, 0, 0, 0);
    resp(3'd3); expect_out("R10", 1, 1, 0, 0, 0);
    resp(3'd4); expect_out("R10", 0, 0, 1, 1, 0);

    // R10: ACK ends quietly, and resets the NAK count
    nak_limit = 3; do_arm();
    resp(3'd1); resp(3'd1); resp(3'd0);
    expect_out("R10", 0, 0, 0, 0, 0);
    chk("R10", "no flag", stalled | err_flag | nak_tmo, 0);
    do_arm();
    resp(3'd1); resp(3'd1); expect_out("R10", 1, 1, 0, 0, 0);
    resp(3'd1); expect_out("R5", 0, 0, 1, 0, 0);

    // R7: STALL
    for (int d = 0; d < 2; d++) begin
      dir_out = d[0]; do_arm();
      chk("R2", "stalled cleared", stalled, 0);
      resp(3'd3);
      resp(3'd2);
      expect_out("R7", 0, 0, 1, 0, 0);
      chk("R7", "stalled", stalled, 1);
      chk("R7", "err_flag", err_flag, 0);
    end

    // R11: reserved codes and idle responses ignored
    dir_out = 1; nak_limit = 0; do_arm();
    resp(3'd3); resp(3'd4);
    resp(3'd6); expect_out("R11", 1, 0, 0, 0, 0);
    resp(3'd7); expect_out("R11", 1, 0, 0, 0, 0);
    resp(3'd5); expect_out("R11", 0, 0, 1, 0, 1);
    resp(3'd2); expect_out("R11", 0, 0, 0, 0, 0);
    chk("R11", "stalled unchanged", stalled, 0);
    resp(3'd1); expect_out("R11", 0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule